// File: doc/BRIEF.md
# Stop-Mode Core Clock Gate Controller

This block decides when the clock of a processor core may be switched off and when it must come back. The core raises a stop request; if software has armed stop mode in the block's 8-bit control register, the core clock enable drops on the next cycle. Peripheral clock enables stay on the whole time, so peripherals can still raise interrupts.

The clock returns when the encoded interrupt priority level seen at the input is above a programmable wake threshold. Threshold 7 blocks all interrupts, and then only a reset brings the clock back. The same register carries a disable bit for a bus clock output pin. Once this bit is set it stays set until reset.

The register is read and written over a simple single-cycle bus at a fixed offset. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `stop_clock_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, core_clk_en is 1, bclk_oe is 1, stopped is 0 and periph_clk_en is 1.
- R2: The control register is at address 0x08. reg_rdata shows it when reg_re is high and the address matches, and reads 0x00 otherwise. A write with any other address changes nothing.
- R3: While bit 7 (stop enable) is 0, stop_req is ignored: core_clk_en stays 1 and stopped stays 0.
- R4: While bit 7 is 1, a stop request that is accepted drives core_clk_en to 0 and stopped to 1 on the next cycle. periph_clk_en stays 1.
- R5: While stopped, an interrupt level L that is strictly greater than the threshold T (bits 6 to 4) makes core_clk_en 1 and stopped 0 on the cycle after L is seen. Threshold 0 accepts levels 1 to 7, and threshold k accepts levels k+1 to 7.
- R6: Interrupt level 0 means that nothing is pending, so it never wakes the core, even when the threshold is 0.
- R7: With threshold 7 no interrupt level wakes the core, and only reset restores core_clk_en.
- R8: A stop request made while the present interrupt level already exceeds the threshold is not accepted.
- R9: Bit 3 drives bclk_oe low when set. Writing 0 to bit 3 does not clear it; only reset does.
- R10: Bits 2 to 0 are reserved. They always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| stop_req | input | 1 | Stop request from the core |
| irq_level | input | 3 | Encoded pending interrupt level, 0 means none |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable, always on |
| bclk_oe | output | 1 | Bus clock output enable |
| stopped | output | 1 | Core is in stop mode |

## Verification
A table of threshold and level pairs tests the wake filter. Each threshold is paired with a level one step below or equal to it and a level just above it, which separates a strict comparison from an inclusive or shifted one. Threshold 7 with level 7 shows that this setting blocks everything. Threshold 0 with level 0 shows that an idle level cannot wake the core. Directed sequences cover stop while disarmed, stop while a qualifying level is already present, and clearing the output disable by a write and then by reset.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int REG_W   = 8;
  localparam int LVL_W   = 3;
  localparam int EN_BIT  = 7;
  localparam int THR_LSB = 4;
  localparam int DIS_BIT = 3;
  localparam int RSV_W   = 3;

  typedef struct packed {
    logic             stop_en;
    logic [LVL_W-1:0] wake_thr;
    logic             bclk_dis;
  } scg_ctrl_t;
endpackage

// File: rtl/scg_rst_sync.sv
module scg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scg_ctrl_reg.sv
module scg_ctrl_reg
  import scg_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output scg_ctrl_t         ctrl
);
  scg_ctrl_t ctrl_q, ctrl_d;
  logic      sel;
  logic      wr_en;

  assign sel   = (addr == CTRL_OFS);
  assign wr_en = we && sel;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.stop_en  = wdata[EN_BIT];
      ctrl_d.wake_thr = wdata[THR_LSB +: LVL_W];
      ctrl_d.bclk_dis = ctrl_q.bclk_dis | wdata[DIS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata = '0;
    if (re && sel) rdata = {ctrl_q.stop_en, ctrl_q.wake_thr, ctrl_q.bclk_dis, {RSV_W{1'b0}}};
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/scg_wake_filter.sv
module scg_wake_filter
  import scg_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr,
  output logic             wake
);
  // Level 0 never exceeds any threshold; the all-ones threshold is never exceeded.
  assign wake = (level > thr);
endmodule

// File: rtl/scg_stop_fsm.sv
module scg_stop_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_en,
  input  logic wake,
  output logic stopped
);
  logic stopped_q, stopped_d;

  always_comb begin
    stopped_d = stopped_q;
    if (stopped_q) begin
      if (wake) stopped_d = 1'b0;
    end else if (stop_req && stop_en && !wake) begin
      stopped_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped_q <= 1'b0;
    else        stopped_q <= stopped_d;
  end

  assign stopped = stopped_q;
endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import scg_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08,
  parameter int                SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              stop_req,
  input  logic [LVL_W-1:0]  irq_level,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              bclk_oe,
  output logic              stopped
);
  logic      rst_sync_n;
  scg_ctrl_t ctrl;
  logic      wake;

  scg_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  scg_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl)
  );

  scg_wake_filter u_filt (
    .level(irq_level), .thr(ctrl.wake_thr), .wake(wake)
  );

  scg_stop_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .stop_req(stop_req), .stop_en(ctrl.stop_en),
    .wake(wake), .stopped(stopped)
  );

  assign core_clk_en   = !stopped;
  assign periph_clk_en = 1'b1;
  assign bclk_oe       = !ctrl.bclk_dis;
endmodule

// File: rtl/scg_checker.sv
module scg_checker
  import scg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic [LVL_W-1:0] irq_level,
  input logic             core_clk_en,
  input logic             bclk_oe,
  input logic [REG_W-1:0] reg_rdata,
  input logic             stop_en,
  input logic [LVL_W-1:0] wake_thr
);
  assert_disarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && !stop_en |=> core_clk_en);

  assert_stop_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && stop_req && stop_en && (irq_level <= wake_thr) |=> !core_clk_en);

  assert_wake_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && (irq_level > wake_thr) |=> core_clk_en);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && (irq_level == '0) |=> !core_clk_en);

  assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && (wake_thr == '1) |=> !core_clk_en);

  assert_pending_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && stop_req && (irq_level > wake_thr) |=> core_clk_en);

  assert_sticky_dis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_oe |=> !bclk_oe);

  assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RSV_W-1:0] == '0);
endmodule

bind stop_clock_ctrl scg_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stop_req(stop_req), .irq_level(irq_level),
  .core_clk_en(core_clk_en), .bclk_oe(bclk_oe), .reg_rdata(reg_rdata),
  .stop_en(ctrl.stop_en), .wake_thr(ctrl.wake_thr)
);

// File: tb/tb_stop_clock_ctrl.sv
`timescale 1ns/1ps
module tb_stop_clock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       stop_req;
  logic [2:0] irq_level;
  logic       core_clk_en, periph_clk_en, bclk_oe, stopped;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  stop_clock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req),
    .irq_level(irq_level), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .bclk_oe(bclk_oe), .stopped(stopped)
  );

  // {threshold[2:0], level[2:0], expect_wake}
  localparam logic [6:0] VEC [12] = '{
    {3'd0, 3'd1, 1'b1}, {3'd0, 3'd7, 1'b1}, {3'd1, 3'd1, 1'b0}, {3'd1, 3'd2, 1'b1},
    {3'd3, 3'd3, 1'b0}, {3'd3, 3'd4, 1'b1}, {3'd5, 3'd5, 1'b0}, {3'd5, 3'd6, 1'b1},
    {3'd6, 3'd6, 1'b0}, {3'd6, 3'd7, 1'b1}, {3'd7, 3'd7, 1'b0}, {3'd2, 3'd5, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #5;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic stop_pulse();
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0; stop_req = 0; irq_level = 0;
    do_reset();

    // R1 reset state
    rd(8'h08, d);
    chk("R1 reg", d, 8'h00);
    chk("R1 core_clk_en", {7'd0, core_clk_en}, 8'd1);
    chk("R1 bclk_oe", {7'd0, bclk_oe}, 8'd1);
    chk("R1 stopped", {7'd0, stopped}, 8'd0);
    chk("R1 periph", {7'd0, periph_clk_en}, 8'd1);

    // R5 R7 table walk
    foreach (VEC[i]) begin
      wr(8'h08, {1'b1, VEC[i][6:4], 4'h0});
      stop_pulse();
      chk("R4 stopped", {7'd0, stopped}, 8'd1);
      chk("R4 core_clk_en", {7'd0, core_clk_en}, 8'd0);
      chk("R4 periph", {7'd0, periph_clk_en}, 8'd1);
      irq_level = VEC[i][3:1];
      tick();
      irq_level = 3'd0;
      chk("R5 R7 wake filter", {7'd0, core_clk_en}, {7'd0, VEC[i][0]});
      chk("R5 stopped clears", {7'd0, stopped}, {7'd0, ~VEC[i][0]});
      if (!VEC[i][0]) begin
        if (VEC[i][6:4] == 3'd7) begin
          repeat (4) tick();
          chk("R7 still stopped", {7'd0, core_clk_en}, 8'd0);
        end
        wr(8'h08, 8'h80);
        irq_level = 3'd7;
        tick();
        irq_level = 3'd0;
      end
    end

    // R6 level 0 with threshold 0
    wr(8'h08, 8'h80);
    stop_pulse();
    irq_level = 3'd0;
    repeat (3) tick();
    chk("R6 level0 no wake", {7'd0, core_clk_en}, 8'd0);
    irq_level = 3'd1;
    tick();
    irq_level = 3'd0;
    chk("R5 level1 wakes", {7'd0, core_clk_en}, 8'd1);

    // R3 disarmed stop
    wr(8'h08, 8'h00);
    stop_pulse();
    tick();
    chk("R3 clk on", {7'd0, core_clk_en}, 8'd1);
    chk("R3 not stopped", {7'd0, stopped}, 8'd0);

    // R8 pending qualifying level
    wr(8'h08, 8'hA0);
    irq_level = 3'd4;
    stop_pulse();
    irq_level = 3'd0;
    chk("R8 not accepted", {7'd0, core_clk_en}, 8'd1);
    irq_level = 3'd2;
    stop_pulse();
    irq_level = 3'd0;
    chk("R8 below threshold accepted", {7'd0, stopped}, 8'd1);

    // R7 reset recovers
    do_reset();
    chk("R7 reset restores", {7'd0, core_clk_en}, 8'd1);
    wr(8'h08, 8'hF0);
    stop_pulse();
    irq_level = 3'd7;
    repeat (3) tick();
    irq_level = 3'd0;
    chk("R7 level7 blocked", {7'd0, core_clk_en}, 8'd0);
    do_reset();
    chk("R7 reset wake", {7'd0, core_clk_en}, 8'd1);

    // R2 addressing
    wr(8'h08, 8'hA0);
    wr(8'h0C, 8'h50);
    rd(8'h08, d);
    chk("R2 other addr ignored", d, 8'hA0);
    rd(8'h0C, d);
    chk("R2 other addr reads 0", d, 8'h00);
    reg_addr = 8'h08;
    #1 chk("R2 no re reads 0", reg_rdata, 8'h00);

    // R10 reserved bits
    wr(8'h08, 8'hF7);
    rd(8'h08, d);
    chk("R10 reserved read 0", d, 8'hF0);

    // R9 sticky output disable
    wr(8'h08, 8'h08);
    chk("R9 oe off", {7'd0, bclk_oe}, 8'd0);
    wr(8'h08, 8'h00);
    rd(8'h08, d);
    chk("R9 bit stays", d, 8'h08);
    chk("R9 oe stays off", {7'd0, bclk_oe}, 8'd0);
    do_reset();
    chk("R9 reset clears", {7'd0, bclk_oe}, 8'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule